// File: doc/BRIEF.md
# E-Clock Peripheral Bus Bridge

This bridge lets a host bus that uses asynchronous strobes reach a slow 8-bit peripheral that runs on its own E clock. The E clock may be synchronous or asynchronous to the host clock. The bridge samples E in the host clock domain and finds its falling edges. It counts those edges from the moment the host starts an access to the selected peripheral.

On the first detected E fall, the bridge asserts the peripheral chip select, which gives the peripheral address setup time. On the second fall, it asserts the transfer acknowledge that ends the host cycle. On that same edge it freezes the data in whichever direction latch is active. The acknowledge removes the chip select at once. Negating the host strobe returns the bridge to idle, and this also aborts an access that has not yet been acknowledged.

The tristate pads sit outside the block. They are driven by enable outputs: one per data direction, plus a pull-down request for the shared open-drain acknowledge line.

Top module: `eclk_bridge`

## Requirements
- R1: After reset and while no access is active, `per_cs` and `ack_pull` are 0, `per_wdata` follows `host_wdata`, and `host_rdata` follows `per_rdata` (both latches transparent).
- R2: `per_cs` goes to 1 within 40 to 80 ns after the first E falling edge that occurs while `sel` and `host_ds` are both 1.
- R3: `ack_pull` goes to 1 after exactly two E falling edges counted from the assertion of `host_ds`, within 40 to 80 ns of the second one.
- R4: In the cycle where `ack_pull` becomes 1, `per_cs` becomes 0. `per_cs` was 1 in the cycle before.
- R5: The active latch captures its input on the edge that raises `ack_pull`, and holds that value while `ack_pull` stays 1, even if the input changes.
- R6: `host_rdata_oe` is 1 exactly when `sel` is 1 and `host_rd` is 1. `per_wdata_oe` is the inverse of `host_rdata_oe`.
- R7: When `host_ds` is 0 on a clock edge, both stages clear: on the next cycle `ack_pull` and `per_cs` are 0 and both latches are transparent again.
- R8: If `host_ds` drops after `per_cs` rises but before the acknowledge, no `ack_pull` pulse occurs for that access.
- R9: With `sel` at 0, `host_ds` produces neither `per_cs` nor `ack_pull`, no matter how many E edges pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| e_clk | input | 1 | Peripheral E clock, any phase relative to `clk` |
| sel | input | 1 | Address-decoded select of the peripheral |
| host_ds | input | 1 | Host data strobe, active high |
| host_rd | input | 1 | 1 = read, 0 = write |
| host_wdata | input | DW | Host write data |
| per_rdata | input | DW | Peripheral read data |
| per_cs | output | 1 | Peripheral chip select, active high |
| per_wdata | output | DW | Write-direction latch output |
| per_wdata_oe | output | 1 | Enable for the write-direction driver |
| host_rdata | output | DW | Read-direction latch output |
| host_rdata_oe | output | 1 | Enable for the read-direction driver |
| ack_pull | output | 1 | 1 = pull the shared acknowledge line asserted; 0 = released |

## Verification
E reaches the sequencer through two sync flops and an edge register, so each result lands 40 to 80 ns after the E fall that causes it. The chip select is due after the first fall and the acknowledge after the second. The bench starts every access just after an E rise, so no edge is still in flight through the synchronizer. It counts raw E falls and measures the time from the last fall to each output change, sampling on the falling host edge. Captured data is compared at the acknowledge, and again two cycles later after the inputs have been changed. The idle state is checked one cycle after the strobe drops.

// File: rtl/eclk_bridge_pkg.sv
package eclk_bridge_pkg;
    typedef struct packed {
        logic cs_stage;
        logic ack_stage;
    } seq_t;
endpackage

// File: rtl/eclk_edge_sync.sv
module eclk_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic e_in,
    output logic e_fall
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   last;
    } sync_t;

    sync_t sync_q, sync_d;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[SYNC_STAGES-2:0], e_in};
        sync_d.last  = sync_q.chain[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    // falling edge of the synchronized E, one cycle wide
    assign e_fall = sync_q.last & ~sync_q.chain[SYNC_STAGES-1];
endmodule

// File: rtl/eclk_seq.sv
module eclk_seq
    import eclk_bridge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic e_fall,
    input  logic sel,
    input  logic ds,
    output logic cs_stage,
    output logic ack_stage,
    output logic ack_set
);
    seq_t seq_q, seq_d;

    always_comb begin
        seq_d = seq_q;
        if (!ds) begin
            seq_d = '0;
        end else if (e_fall) begin
            if (!seq_q.cs_stage) seq_d.cs_stage  = sel;
            else                 seq_d.ack_stage = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign cs_stage  = seq_q.cs_stage;
    assign ack_stage = seq_q.ack_stage;
    assign ack_set   = seq_d.ack_stage & ~seq_q.ack_stage;

    p_cs_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.cs_stage) |-> $past(e_fall && sel && ds));

    p_ack_second_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.ack_stage) |-> $past(seq_q.cs_stage && e_fall));

    p_strobe_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ds |=> (!seq_q.cs_stage && !seq_q.ack_stage));

    p_abort_no_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.cs_stage && !seq_q.ack_stage && !ds) |=> !seq_q.ack_stage);
endmodule

// File: rtl/eclk_hold_latch.sv
module eclk_hold_latch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic          hold,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] held_q, held_d;

    always_comb begin
        held_d = held_q;
        if (cap) held_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_d;
    end

    assign dout = hold ? held_q : din;

    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold)) |-> $stable(dout));
endmodule

// File: rtl/eclk_bridge.sv
module eclk_bridge #(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          e_clk,
    input  logic          sel,
    input  logic          host_ds,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    input  logic [DW-1:0] per_rdata,
    output logic          per_cs,
    output logic [DW-1:0] per_wdata,
    output logic          per_wdata_oe,
    output logic [DW-1:0] host_rdata,
    output logic          host_rdata_oe,
    output logic          ack_pull
);
    logic e_fall, cs_stage, ack_stage, ack_set;
    logic read_dir;

    eclk_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .e_in(e_clk), .e_fall(e_fall)
    );

    eclk_seq i_seq (
        .clk(clk), .rst_n(rst_n), .e_fall(e_fall), .sel(sel), .ds(host_ds),
        .cs_stage(cs_stage), .ack_stage(ack_stage), .ack_set(ack_set)
    );

    eclk_hold_latch #(.DW(DW)) i_wr_latch (
        .clk(clk), .rst_n(rst_n), .cap(ack_set), .hold(ack_stage),
        .din(host_wdata), .dout(per_wdata)
    );

    eclk_hold_latch #(.DW(DW)) i_rd_latch (
        .clk(clk), .rst_n(rst_n), .cap(ack_set), .hold(ack_stage),
        .din(per_rdata), .dout(host_rdata)
    );

    assign read_dir      = sel & host_rd;
    assign host_rdata_oe = read_dir;
    assign per_wdata_oe  = ~read_dir;
    assign per_cs        = cs_stage & ~ack_stage;
    assign ack_pull      = ack_stage;

    p_no_ack_unselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_cs && !ack_pull && !sel) |=> !ack_pull);
endmodule

// File: tb/test_eclk_bridge.sv
`timescale 1ns/100ps
module test_eclk_bridge;
    localparam int DW = 8;

    typedef struct {
        logic          rd;
        logic [DW-1:0] data;
    } exp_t;

    logic          clk = 0, rst_n = 0, e_clk = 1;
    logic          sel = 0, host_ds = 0, host_rd = 0;
    logic [DW-1:0] host_wdata = '0, per_rdata = '0;
    logic          per_cs, per_wdata_oe, host_rdata_oe, ack_pull;
    logic [DW-1:0] per_wdata, host_rdata;

    int  n_chk = 0, n_bad = 0;
    real e_half = 110.0;
    int  fall_cnt = 0;
    real last_fall = 0.0, first_fall = 0.0;
    bit  done = 0;
    exp_t sb[$];

    always #10 clk = ~clk;
    initial begin
        #3.1;
        forever begin
            #(e_half) e_clk = 0;
            #(e_half) e_clk = 1;
        end
    end

    eclk_bridge #(.DW(DW)) i_eclk_bridge (
        .clk(clk), .rst_n(rst_n), .e_clk(e_clk), .sel(sel), .host_ds(host_ds),
        .host_rd(host_rd), .host_wdata(host_wdata), .per_rdata(per_rdata),
        .per_cs(per_cs), .per_wdata(per_wdata), .per_wdata_oe(per_wdata_oe),
        .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe), .ack_pull(ack_pull)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge e_clk) begin
        if (host_ds) begin
            fall_cnt++;
            last_fall = $realtime;
            if (fall_cnt == 1) first_fall = $realtime;
        end
    end

    // monitor: scoreboard compare at acknowledge and chip-select timing
    logic prev_ack = 0, prev_cs = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (per_cs && !prev_cs) begin
                check(fall_cnt == 1, "R2 falls before cs", fall_cnt, 1);
                check(($realtime - first_fall) >= 40.0 && ($realtime - first_fall) <= 80.0,
                      "R2 cs latency ns", int'($realtime - first_fall), 60);
            end
            if (ack_pull && !prev_ack) begin
                exp_t e;
                check(sb.size() > 0, "R3 unexpected ack", sb.size(), 1);
                if (sb.size() > 0) begin
                    e = sb.pop_front();
                    if (e.rd) check(host_rdata == e.data, "R5 read capture", host_rdata, e.data);
                    else      check(per_wdata == e.data, "R5 write capture", per_wdata, e.data);
                end
                check(fall_cnt == 2, "R3 falls before ack", fall_cnt, 2);
                check(($realtime - last_fall) >= 40.0 && ($realtime - last_fall) <= 80.0,
                      "R3 ack latency ns", int'($realtime - last_fall), 60);
                check(!per_cs && prev_cs, "R4 cs dropped by ack", {prev_cs, per_cs}, 2);
            end
        end
        prev_ack = ack_pull;
        prev_cs  = per_cs;
    end

    // driver: one full access
    task automatic access(input logic rd, input logic [DW-1:0] d);
        exp_t e;
        int   t;
        e.rd = rd; e.data = d;
        sb.push_back(e);
        @(posedge e_clk);
        @(negedge clk);
        sel = 1; host_rd = rd;
        if (rd) per_rdata = d; else host_wdata = d;
        #1;
        check(host_rdata_oe == rd && per_wdata_oe == !rd, "R6 direction enables",
              {host_rdata_oe, per_wdata_oe}, {rd, !rd});
        fall_cnt = 0;
        host_ds = 1;
        t = 0;
        while (!ack_pull && t < 100) begin @(negedge clk); t++; end
        check(ack_pull, "R3 ack arrives", ack_pull, 1);
        repeat (2) @(negedge clk);
        if (rd) per_rdata = ~d; else host_wdata = ~d;
        #1;
        if (rd) check(host_rdata == d, "R5 read held", host_rdata, d);
        else    check(per_wdata == d, "R5 write held", per_wdata, d);
        @(negedge clk);
        host_ds = 0;
        @(negedge clk); @(negedge clk);
        check(!ack_pull && !per_cs, "R7 idle after strobe", {ack_pull, per_cs}, 0);
        if (rd) check(host_rdata == ~d, "R7 read latch transparent", host_rdata, ~d);
        else    check(per_wdata == ~d, "R7 write latch transparent", per_wdata, ~d);
        sel = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        host_wdata = 8'h3c; per_rdata = 8'hc3;
        #1;
        check(!ack_pull && !per_cs, "R1 reset outputs", {ack_pull, per_cs}, 0);
        check(per_wdata == 8'h3c && host_rdata == 8'hc3, "R1 latches transparent in reset",
              per_wdata, 8'h3c);
        rst_n = 1;
        repeat (4) @(negedge clk);
        host_wdata = 8'h5a; per_rdata = 8'ha5;
        #1;
        check(per_wdata == 8'h5a && host_rdata == 8'ha5, "R1 idle transparency",
              host_rdata, 8'ha5);

        access(0, 8'h11);
        access(1, 8'h9e);
        e_half = 130.0;
        access(1, 8'h42);
        access(0, 8'hf0);
        e_half = 157.3;
        access(0, 8'h07);
        access(1, 8'hd8);
        e_half = 213.7;
        access(1, 8'h81);
        access(0, 8'h7e);

        // R8: abort between chip select and acknowledge
        @(posedge e_clk); @(negedge clk);
        sel = 1; host_rd = 0; fall_cnt = 0; host_ds = 1;
        while (!per_cs) @(negedge clk);
        @(negedge clk);
        host_ds = 0;
        @(negedge clk); @(negedge clk);
        check(!per_cs, "R8 cs cleared on abort", per_cs, 0);
        repeat (2) @(negedge e_clk);
        repeat (5) @(negedge clk);
        check(!ack_pull && prev_ack == 0, "R8 no ack after abort", ack_pull, 0);
        sel = 0;

        // R9: strobe without select
        @(negedge clk);
        sel = 0; host_rd = 1; host_ds = 1;
        #1;
        check(host_rdata_oe == 0 && per_wdata_oe == 1, "R6 enables without select",
              {host_rdata_oe, per_wdata_oe}, 1);
        begin
            int seen = 0;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (per_cs || ack_pull) seen++;
            end
            repeat (3) @(negedge e_clk);
            repeat (5) @(negedge clk);
            check(seen == 0 && !per_cs && !ack_pull, "R9 no cs or ack unselected", seen, 0);
        end
        host_ds = 0;
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R3 every access acknowledged", sb.size(), 0);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule